// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block finds the most significant asserted request among a set of active-low request lines and reports its position. It is made of identical eight-line encoder slices. Each slice has an active-low enable input. When enabled, it produces the complemented index of its highest asserted line. It also has two active-low handshake outputs. One says the slice found a request. The other hands the enable down to the next, lower-priority slice when the slice found nothing.

The top level chains four slices into a 32-line encoder. The slice that covers the highest lines always has its enable held active. Each slice's pass-on output enables the slice below it, so at most one slice reports a hit. The upper index bits come from which slice reports a hit. The lower bits come from merging the slices' complemented codes, because idle or disabled slices drive all ones. The result is a plain binary index with an active-high valid flag. The block is purely combinational.

Top module: `prio_enc_cascade`

## Requirements
- R1: A slice whose enable input is high drives its code outputs, its hit flag and its pass-on flag all high, whatever its requests are.
- R2: An enabled slice with at least one request line low drives on its code outputs the bitwise complement of the position of the highest-numbered low line. Line 7 ranks first and line 0 last.
- R3: An enabled slice with at least one request line low drives its hit flag low and its pass-on flag high.
- R4: An enabled slice with no request line low drives its pass-on flag low, its hit flag high and its code outputs all high.
- R5: `valid` is 1 exactly when at least one bit of `req_n` is 0.
- R6: When `valid` is 1, `index` is the position of the highest-numbered 0 bit of `req_n`. Bit 31 ranks first, so with every line asserted `index` is 31.
- R7: When no bit of `req_n` is 0, `index` is 0 and `valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 32 | Request lines, active low; bit 31 has the highest priority |
| index | output | 5 | Binary position of the winning request; 0 when idle |
| valid | output | 1 | High when any request line is asserted |

## Verification
The bench builds the top level with its default shape of four slices of eight lines. With that shape, every slice boundary and every upper-index value from 0 to 3 is reached by single-line patterns at all 32 positions. A second instance, a lone eight-line slice, is driven through all 256 request patterns with its enable both high and low. This covers every case of the enable, hit and pass-on handshakes, which cannot be seen at the cascade's ports. Random patterns, both sparse and dense, check that merging the slices' low bits never lets an idle slice disturb the result.

// File: rtl/prio_enc_pkg.sv
// Package prio_enc_pkg
// Shared defaults for the cascaded priority encoder.
// Assumes the slice width and the slice count are powers of two, with at least two slices.
package prio_enc_pkg;
    localparam int DEF_SLICE_W = 8;
    localparam int DEF_SLICES  = 4;
endpackage

// File: rtl/prio_enc_unit.sv
// Module prio_enc_unit
// One priority-encoder slice with active-low requests, codes and handshakes.
// When enabled, it outputs the complemented index of the highest low request line.
// hit_n goes low when something was found. pass_n goes low when nothing was found,
// which enables the next lower slice. When disabled, every output is high.
// Assumes REQ_W is a power of two of at least 2. Purely combinational.
module prio_enc_unit #(
    parameter  int REQ_W  = prio_enc_pkg::DEF_SLICE_W,
    localparam int CODE_W = $clog2(REQ_W)
) (
    input  logic              en_n,
    input  logic [REQ_W-1:0]  req_n,
    output logic [CODE_W-1:0] code_n,
    output logic              hit_n,
    output logic              pass_n
);
    logic              any_req;
    logic [CODE_W-1:0] top_pos;

    // Find the highest asserted line; later (higher) lines overwrite earlier ones.
    always_comb begin
        any_req = ~&req_n;
        top_pos = '0;
        for (int i = 0; i < REQ_W; i++) begin
            if (!req_n[i]) top_pos = CODE_W'(i);
        end
    end

    // Form the active-low outputs from the enable and the search result.
    always_comb begin
        code_n = (!en_n && any_req) ? ~top_pos : '1;
        hit_n  = !(!en_n && any_req);
        pass_n = !(!en_n && !any_req);
    end
endmodule

// File: rtl/grp_index_enc.sv
// Module grp_index_enc
// Converts the active-low hit flags of the chained slices into the upper index bits.
// Assumes at most one flag is low at a time, which the enable chain guarantees.
// Gives zero when no flag is low.
module grp_index_enc #(
    parameter  int SLICES = prio_enc_pkg::DEF_SLICES,
    localparam int HI_W   = $clog2(SLICES)
) (
    input  logic [SLICES-1:0] hit_n,
    output logic [HI_W-1:0]   hi_bits
);
    // OR together the numbers of the slices that report a hit.
    always_comb begin
        hi_bits = '0;
        for (int k = 0; k < SLICES; k++) begin
            if (!hit_n[k]) hi_bits = hi_bits | HI_W'(k);
        end
    end
endmodule

// File: rtl/code_merge.sv
// Module code_merge
// Merges the slices' active-low codes with an AND and returns the active-high low index bits.
// Assumes every slice that does not report a hit drives all ones.
module code_merge #(
    parameter int SLICES = prio_enc_pkg::DEF_SLICES,
    parameter int CODE_W = 3
) (
    input  logic [SLICES*CODE_W-1:0] codes_n,
    output logic [CODE_W-1:0]        lo_bits
);
    logic [CODE_W-1:0] acc_n;

    // AND the codes together; idle slices contribute ones and drop out.
    always_comb begin
        acc_n = '1;
        for (int k = 0; k < SLICES; k++) begin
            acc_n = acc_n & codes_n[k*CODE_W +: CODE_W];
        end
        lo_bits = ~acc_n;
    end
endmodule

// File: rtl/prio_enc_cascade.sv
// Module prio_enc_cascade
// A wide priority encoder built from SLICES chained slices of SLICE_W lines each.
// Slice SLICES-1 holds the top lines and is always enabled. Each slice's pass-on
// output enables the slice below it. Reports a binary index and an active-high valid.
// Assumes power-of-two SLICE_W and SLICES, with SLICES >= 2. Purely combinational.
module prio_enc_cascade #(
    parameter  int SLICE_W = prio_enc_pkg::DEF_SLICE_W,
    parameter  int SLICES  = prio_enc_pkg::DEF_SLICES,
    localparam int REQ_W   = SLICE_W * SLICES,
    localparam int LO_W    = $clog2(SLICE_W),
    localparam int HI_W    = $clog2(SLICES),
    localparam int IDX_W   = LO_W + HI_W
) (
    input  logic [REQ_W-1:0] req_n,
    output logic [IDX_W-1:0] index,
    output logic             valid
);
    logic [SLICES:0]        en_chain_n;
    logic [SLICES-1:0]      hit_n;
    logic [SLICES*LO_W-1:0] codes_n;
    logic [HI_W-1:0]        hi_bits;
    logic [LO_W-1:0]        lo_bits;

    // The top slice is always enabled.
    assign en_chain_n[SLICES] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < SLICES; k++) begin : g_slice
            prio_enc_unit #(.REQ_W(SLICE_W)) u_slice (
                .en_n   (en_chain_n[k+1]),
                .req_n  (req_n[k*SLICE_W +: SLICE_W]),
                .code_n (codes_n[k*LO_W +: LO_W]),
                .hit_n  (hit_n[k]),
                .pass_n (en_chain_n[k])
            );
        end
    endgenerate

    grp_index_enc #(.SLICES(SLICES)) u_grp (
        .hit_n   (hit_n),
        .hi_bits (hi_bits)
    );

    code_merge #(.SLICES(SLICES), .CODE_W(LO_W)) u_merge (
        .codes_n (codes_n),
        .lo_bits (lo_bits)
    );

    // Join the index halves. The enable reaches past the bottom slice only when nothing is asserted.
    always_comb begin
        index = {hi_bits, lo_bits};
        valid = en_chain_n[0];
    end
endmodule

// File: rtl/prio_enc_chk.sv
// Module unit_chk
// Checks the handshake and code rules of one slice. Bound to every prio_enc_unit.
module unit_chk #(
    parameter  int REQ_W  = 8,
    localparam int CODE_W = $clog2(REQ_W)
) (
    input logic              en_n,
    input logic [REQ_W-1:0]  req_n,
    input logic [CODE_W-1:0] code_n,
    input logic              hit_n,
    input logic              pass_n
);
    // Relate slice outputs to slice inputs.
    always_comb begin
        if (en_n) begin
            AST_OFF_QUIET: assert (&code_n && hit_n && pass_n) else $error("disabled slice active"); // R1
        end
        if (!en_n && !(&req_n)) begin
            AST_CODE_TOP: assert (((~req_n) >> (~code_n)) == REQ_W'(1)) else $error("slice code wrong"); // R2
            AST_HIT_FLAGS: assert (!hit_n && pass_n) else $error("slice hit flags wrong"); // R3
        end
        if (!en_n && (&req_n)) begin
            AST_PASS_IDLE: assert (!pass_n && hit_n && (&code_n)) else $error("idle slice flags wrong"); // R4
        end
    end
endmodule

// Module cascade_chk
// Checks the index and valid outputs of the cascade against its request lines.
module cascade_chk #(
    parameter int REQ_W  = 32,
    parameter int IDX_W  = 5,
    parameter int SLICES = 4
) (
    input logic [REQ_W-1:0]  req_n,
    input logic [IDX_W-1:0]  index,
    input logic              valid,
    input logic [SLICES-1:0] hit_n
);
    // Relate the cascade outputs to its request lines.
    always_comb begin
        AST_VALID_ANY: assert (valid == !(&req_n)) else $error("valid wrong"); // R5
        AST_ONE_GROUP: assert ($onehot0(~hit_n)) else $error("several slices hit"); // R6
        if (valid) begin
            AST_INDEX_TOP: assert (((~req_n) >> index) == REQ_W'(1)) else $error("index wrong"); // R6
        end else begin
            AST_IDLE_ZERO: assert (index == '0) else $error("idle index not zero"); // R7
        end
    end
endmodule

bind prio_enc_unit unit_chk #(.REQ_W(REQ_W)) u_unit_chk (
    .en_n   (en_n),
    .req_n  (req_n),
    .code_n (code_n),
    .hit_n  (hit_n),
    .pass_n (pass_n)
);

bind prio_enc_cascade cascade_chk #(.REQ_W(REQ_W), .IDX_W(IDX_W), .SLICES(SLICES)) u_casc_chk (
    .req_n (req_n),
    .index (index),
    .valid (valid),
    .hit_n (hit_n)
);

// File: tb/tb_prio_enc_cascade.sv
// Bench for prio_enc_cascade, plus a lone slice for the handshake rules.
// Inputs change on the rising edge. Outputs are sampled on the falling edge.
module tb_prio_enc_cascade;
    localparam int REQ_W = 32;

    logic        clk = 1'b0;
    logic [31:0] req_n = '1;
    logic [4:0]  index;
    logic        valid;

    logic       u_en_n = 1'b1;
    logic [7:0] u_req_n = '1;
    logic [2:0] u_code_n;
    logic       u_hit_n;
    logic       u_pass_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    prio_enc_cascade dut (.req_n(req_n), .index(index), .valid(valid));

    prio_enc_unit #(.REQ_W(8)) unit_dut (
        .en_n(u_en_n), .req_n(u_req_n), .code_n(u_code_n),
        .hit_n(u_hit_n), .pass_n(u_pass_n)
    );

    // Watchdog: counts a hang as a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Position of the highest zero bit, or -1 when there is none.
    function automatic int top_zero(input logic [31:0] r, input int w);
        int p = -1;
        for (int i = 0; i < w; i++) if (!r[i]) p = i;
        return p;
    endfunction

    task automatic check_top(input logic [31:0] r);
        int p;
        @(posedge clk);
        req_n = r;
        @(negedge clk);
        p = top_zero(r, REQ_W);
        checks++;
        if (valid !== (p >= 0)) begin
            errors++;
            $display("FAIL R5 req_n=%h valid actual %b expected %b", r, valid, p >= 0);
        end
        checks++;
        if (p < 0) begin
            if (index !== 5'd0) begin
                errors++;
                $display("FAIL R7 idle index actual %0d expected 0", index);
            end
        end else if (index !== 5'(p)) begin
            errors++;
            $display("FAIL R6 req_n=%h index actual %0d expected %0d", r, index, p);
        end
    endtask

    task automatic check_unit(input logic en, input logic [7:0] r);
        int p;
        logic [2:0] e_code;
        logic e_hit, e_pass;
        @(posedge clk);
        u_en_n = en;
        u_req_n = r;
        @(negedge clk);
        p = top_zero({24'hFFFFFF, r}, 8);
        if (en) begin
            e_code = 3'b111; e_hit = 1'b1; e_pass = 1'b1;      // R1
        end else if (p < 0) begin
            e_code = 3'b111; e_hit = 1'b1; e_pass = 1'b0;      // R4
        end else begin
            e_code = ~3'(p); e_hit = 1'b0; e_pass = 1'b1;      // R2, R3
        end
        checks++;
        if ({u_code_n, u_hit_n, u_pass_n} !== {e_code, e_hit, e_pass}) begin
            errors++;
            $display("FAIL %s en_n=%b req_n=%h actual code/hit/pass %b/%b/%b expected %b/%b/%b",
                     en ? "R1" : (p < 0 ? "R4" : "R2/R3"), en, r,
                     u_code_n, u_hit_n, u_pass_n, e_code, e_hit, e_pass);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7919);
        // Reset state: everything idle (R7).
        @(negedge clk);
        checks++;
        if (valid !== 1'b0 || index !== 5'd0) begin
            errors++;
            $display("FAIL R7 initial idle actual valid=%b index=%0d expected 0/0", valid, index);
        end
        // Exhaustive slice handshakes: R1 with enable high; R2, R3, R4 with enable low.
        for (int en = 0; en < 2; en++)
            for (int p = 0; p < 256; p++) check_unit(en[0], p[7:0]);
        // Directed cascade corners: all idle (R7), all asserted (R6), single lines (R6).
        check_top(32'hFFFF_FFFF);
        check_top(32'h0000_0000);
        for (int i = 0; i < 32; i++) check_top(~(32'd1 << i));
        // A single line plus every line below it asserted.
        for (int i = 0; i < 32; i++) check_top(~((32'd2 << i) - 32'd1));
        // Random: sparse and dense requests (R5, R6).
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] r;
            if (n % 3 == 0) r = $urandom;
            else r = $urandom | $urandom | $urandom | $urandom;
            check_top(r);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule